// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that streams data between one fixed peripheral address and a memory address that moves forward. It describes each transfer to the downstream data path one beat at a time. Each beat carries the peripheral address, the memory address, the direction and the beat width. The data path itself lives outside this block.

The channel has two ways to run.
- **Single-shot mode:** it uses four working words that software writes over a small register port. These are the peripheral address, the memory address, a size word and a link word.
- **Chained mode:** it fetches those same four words from memory as a descriptor, through a request/response read port. It then follows the link word from one descriptor to the next until a descriptor marks the end of the chain.

The size word carries both the beat count and the beat width. The link word carries the continue/stop decision, the completion-interrupt request and the next descriptor's address. A two-bit status output reports what the channel is doing. An interrupt pulse marks each completion that asked for one, and an error pulse marks a rejected size word.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the channel is idle: status reads 0, and xfer_valid, rd_valid, irq and err are all low.
- R2: A start pulse is taken only while status is 0 and mode is 1 (chained) or 2 (single-shot). A start with mode 0 or 3, or a start while the channel is busy, changes nothing.
- R3: A transfer issues exactly as many beats as the count field (size word bits 10:0). The peripheral address stays fixed from beat to beat. The memory address starts at the loaded value and rises by the beat width after every accepted beat.
- R4: Size word bits 13:12 choose the beat width: code 3 is 1 byte (xfer_size 0), code 2 is 2 bytes (xfer_size 1) and code 0 is 4 bytes (xfer_size 2). xfer_size never reads 3.
- R5: Width code 1 is rejected. So is a count above 0x3FF with a 1- or 2-byte width, or above 0x7FF with a 4-byte width. A rejected size word gives a one-cycle err pulse while status is 2, then status 0, with no beats.
- R6: Link word bit 0 requests a one-cycle irq pulse when the descriptor's beats are done. Bit 1 tells chained mode to fetch the next descriptor; single-shot mode ignores bit 1. A count of 0 gives no beats, but the link flags still take effect.
- R7: In chained mode the first descriptor address is the link register with its two low bits cleared. Words are fetched from that address +0, +4, +8 and +12 and become, in that order, the peripheral address, memory address, size word and link word.
- R8: Status reads 0 when idle, 1 while fetching a descriptor, 2 while checking or finishing a descriptor, and 3 while beats are offered. xfer_valid is high only in status 3, and rd_valid only in status 1.
- R9: If mode drops to 0 while beats are offered, the beat being offered still completes, and the channel then returns to status 0 with no irq.
- R10: Register writes at byte offsets 0x0, 0x4, 0x8 and 0xC load the peripheral address, memory address, size word and link word. Writes are ignored unless status is 0.
- R11: The direction input is captured at start. xfer_to_dev is 1 for memory to peripheral and 0 for peripheral to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | ADDR_W | Register write data |
| mode | input | 2 | 0 off, 1 chained, 2 single-shot |
| dir | input | 1 | 1 = memory to peripheral |
| start | input | 1 | Start request pulse |
| rd_valid | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Descriptor word address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | ADDR_W | Read data |
| xfer_valid | output | 1 | Beat offered |
| xfer_ready | input | 1 | Beat accepted |
| xfer_dev_addr | output | ADDR_W | Peripheral address of beat |
| xfer_mem_addr | output | ADDR_W | Memory address of beat |
| xfer_to_dev | output | 1 | Beat direction |
| xfer_size | output | 2 | log2 of beat bytes |
| status | output | 2 | Channel status |
| irq | output | 1 | Completion interrupt pulse |
| err | output | 1 | Size-word error pulse |

## Verification
Some properties are checked on every cycle:
- A stalled beat holds its addresses, and an accepted beat advances the memory address by exactly its own width.
- Beats and descriptor reads appear only under their status codes.
- An error pulse is always followed by idle.
- Dropping the mode during an accepted beat ends the run.

Other behaviour only the directed scenarios can show:
- The exact beat count.
- Which descriptor word lands in which field.
- The masking of the link flags before a fetch.
- The number of interrupts over a mixed chain.
- That writes and starts made while busy leave the running transfer untouched.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_MOVE, S_END} chan_fsm_e;

   localparam logic [1:0] STS_IDLE = 2'd0;
   localparam logic [1:0] STS_DESC = 2'd1;
   localparam logic [1:0] STS_WAIT = 2'd2;
   localparam logic [1:0] STS_MOVE = 2'd3;

   localparam logic [1:0] MODE_OFF    = 2'd0;
   localparam logic [1:0] MODE_CHAIN  = 2'd1;
   localparam logic [1:0] MODE_SINGLE = 2'd2;

   localparam logic [1:0] WC_BYTE = 2'd3;
   localparam logic [1:0] WC_HALF = 2'd2;
   localparam logic [1:0] WC_WORD = 2'd0;

   localparam int WIDTH_LSB      = 12;
   localparam int WORDS_PER_DESC = 4;
endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
   parameter int ADDR_W = 32,
   parameter int WORDS  = 4,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] base,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic              rsp_valid,
   output logic              cap_en,
   output logic [IDX_W-1:0]  cap_idx,
   output logic              done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

   if (WORDS < 2) begin : g_bad_words
      $error("descriptor needs at least two words");
   end

   typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fetch_e;
   fetch_e            st;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= F_IDLE;
         idx    <= '0;
         base_q <= '0;
      end else begin
         case (st)
            F_IDLE: if (go) begin
               base_q <= base;
               idx    <= '0;
               st     <= F_REQ;
            end
            F_REQ: if (rd_ready) st <= F_RSP;
            F_RSP: if (rsp_valid) begin
               if (idx == LAST) st <= F_IDLE;
               else begin
                  idx <= idx + 1'b1;
                  st  <= F_REQ;
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_valid = (st == F_REQ);
      rd_addr  = base_q + ADDR_W'({idx, 2'b00});
      cap_en   = (st == F_RSP) && rsp_valid;
      cap_idx  = idx;
      done     = cap_en && (idx == LAST);
   end
endmodule

// File: rtl/dma_size_check.sv
module dma_size_check import dma_chain_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 11,
   parameter int NARROW_MAX = 'h3FF,
   parameter int WIDE_MAX   = 'h7FF
) (
   input  logic [ADDR_W-1:0] size_word,
   output logic              legal,
   output logic [CNT_W-1:0]  cnt,
   output logic [1:0]        sz_log2
);
   if (CNT_W > WIDTH_LSB || WIDE_MAX >= (1 << CNT_W) || NARROW_MAX > WIDE_MAX) begin : g_bad_cfg
      $error("count field does not fit below the width code");
   end

   logic [1:0]       wcode;
   logic [CNT_W-1:0] lim;
   logic             bad_code;

   always_comb begin
      wcode    = size_word[WIDTH_LSB+1:WIDTH_LSB];
      cnt      = size_word[CNT_W-1:0];
      bad_code = 1'b0;
      case (wcode)
         WC_BYTE: begin sz_log2 = 2'd0; lim = CNT_W'(NARROW_MAX); end
         WC_HALF: begin sz_log2 = 2'd1; lim = CNT_W'(NARROW_MAX); end
         WC_WORD: begin sz_log2 = 2'd2; lim = CNT_W'(WIDE_MAX);   end
         default: begin sz_log2 = 2'd2; lim = '0; bad_code = 1'b1; end
      endcase
      legal = !bad_code && (cnt <= lim);
   end
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan import dma_chain_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 11,
   parameter int NARROW_MAX = 'h3FF,
   parameter int WIDE_MAX   = 'h7FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [1:0]        mode,
   input  logic              dir,
   input  logic              start,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ready,
   input  logic              rsp_valid,
   input  logic [ADDR_W-1:0] rsp_data,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ADDR_W-1:0] xfer_dev_addr,
   output logic [ADDR_W-1:0] xfer_mem_addr,
   output logic              xfer_to_dev,
   output logic [1:0]        xfer_size,
   output logic [1:0]        status,
   output logic              irq,
   output logic              err
);
   localparam int NW = WORDS_PER_DESC;
   localparam int IW = $clog2(NW);

   if (ADDR_W < WIDTH_LSB + 2) begin : g_bad_addr
      $error("address width too small for the size word");
   end

   chan_fsm_e         st;
   logic [CNT_W-1:0]  left;
   logic              run_sg, dir_q, halt, beat, host_wr, follow;
   logic              fetch_go, cap_en, fetch_done, legal;
   logic [IW-1:0]     cap_idx;
   logic [CNT_W-1:0]  cnt;
   logic [1:0]        sz;
   logic [ADDR_W-1:0] step, dev_w, mem_w, size_w, link_w, link_base;

   for (genvar gi = 0; gi < NW; gi++) begin : g_word
      logic [ADDR_W-1:0] q;
      logic              hit_host, hit_cap;
      assign hit_host = host_wr && (cfg_addr[3:2] == IW'(gi));
      assign hit_cap  = cap_en && (cap_idx == IW'(gi));
      if (gi == 1) begin : g_inc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (hit_host) q <= cfg_wdata;
            else if (hit_cap)  q <= rsp_data;
            else if (beat)     q <= q + step;
         end
      end else begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (hit_host) q <= cfg_wdata;
            else if (hit_cap)  q <= rsp_data;
         end
      end
   end

   assign dev_w     = g_word[0].q;
   assign mem_w     = g_word[1].q;
   assign size_w    = g_word[2].q;
   assign link_w    = g_word[3].q;
   assign link_base = {link_w[ADDR_W-1:2], 2'b00};

   dma_size_check #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NARROW_MAX(NARROW_MAX), .WIDE_MAX(WIDE_MAX)
   ) u_size (
      .size_word(size_w), .legal(legal), .cnt(cnt), .sz_log2(sz)
   );

   dma_desc_fetch #(.ADDR_W(ADDR_W), .WORDS(NW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(fetch_go), .base(link_base),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rsp_valid(rsp_valid), .cap_en(cap_en), .cap_idx(cap_idx), .done(fetch_done)
   );

   assign halt     = (mode == MODE_OFF);
   assign host_wr  = cfg_we && (st == S_IDLE);
   assign beat     = (st == S_MOVE) && xfer_ready;
   assign step     = ADDR_W'(1) << sz;
   assign follow   = run_sg && link_w[1];
   assign fetch_go = ((st == S_IDLE) && start && (mode == MODE_CHAIN)) ||
                     ((st == S_END) && !halt && follow);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         left   <= '0;
         run_sg <= 1'b0;
         dir_q  <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start && mode == MODE_CHAIN) begin
                  st     <= S_FETCH;
                  run_sg <= 1'b1;
                  dir_q  <= dir;
               end else if (start && mode == MODE_SINGLE) begin
                  st     <= S_CHECK;
                  run_sg <= 1'b0;
                  dir_q  <= dir;
               end
            end
            S_FETCH: if (fetch_done) st <= S_CHECK;
            S_CHECK: begin
               if (halt || !legal)  st <= S_IDLE;
               else if (cnt == '0)  st <= S_END;
               else begin
                  left <= cnt;
                  st   <= S_MOVE;
               end
            end
            S_MOVE: if (beat) begin
               left <= left - 1'b1;
               if (halt)                    st <= S_IDLE;
               else if (left == CNT_W'(1))  st <= S_END;
            end
            S_END:   st <= fetch_go ? S_FETCH : S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         S_IDLE:  status = STS_IDLE;
         S_FETCH: status = STS_DESC;
         S_MOVE:  status = STS_MOVE;
         default: status = STS_WAIT;
      endcase
      xfer_valid    = (st == S_MOVE);
      xfer_dev_addr = dev_w;
      xfer_mem_addr = mem_w;
      xfer_to_dev   = dir_q;
      xfer_size     = sz;
      irq           = (st == S_END) && link_w[0] && !halt;
      err           = (st == S_CHECK) && !legal && !halt;
   end
endmodule

// File: rtl/dma_chain_chan_chk.sv
module dma_chain_chan_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              start,
   input logic              rd_valid,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [ADDR_W-1:0] xfer_dev_addr,
   input logic [ADDR_W-1:0] xfer_mem_addr,
   input logic [1:0]        xfer_size,
   input logic [1:0]        status,
   input logic              irq,
   input logic              err
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      status == 2'd0 |-> !xfer_valid && !rd_valid && !irq && !err);

   a_r2_off_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      status == 2'd0 && start && mode == 2'd0 |=> status == 2'd0);

   a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_mem_addr) && $stable(xfer_dev_addr));

   a_r3_mem_advance: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && xfer_ready |=>
         !xfer_valid ||
         (xfer_mem_addr == $past(xfer_mem_addr) + (ADDR_W'(1) << $past(xfer_size)) &&
          xfer_dev_addr == $past(xfer_dev_addr)));

   a_r4_size_code: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> xfer_size != 2'd3);

   a_r5_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> status == 2'd2 ##1 status == 2'd0);

   a_r6_irq_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq && err));

   a_r8_beat_status: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> status == 2'd3);

   a_r8_fetch_status: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> status == 2'd1);

   a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && xfer_ready && mode == 2'd0 |=> status == 2'd0 && !irq);
endmodule

bind dma_chain_chan dma_chain_chan_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dma_chain_chan.sv
`timescale 1ns/1ps
module sim_dma_chain_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [1:0]  mode = 2'd0;
   logic        dir = 1'b0;
   logic        start = 1'b0;
   logic        rd_valid, rd_ready;
   logic [31:0] rd_addr;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic        xfer_valid, xfer_ready = 1'b1, xfer_to_dev;
   logic [31:0] xfer_dev_addr, xfer_mem_addr;
   logic [1:0]  xfer_size, status;
   logic        irq, err;

   always #10 clk = ~clk;
   assign rd_ready = 1'b1;

   dma_chain_chan u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .mode(mode), .dir(dir), .start(start),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_dev_addr(xfer_dev_addr),
      .xfer_mem_addr(xfer_mem_addr), .xfer_to_dev(xfer_to_dev), .xfer_size(xfer_size),
      .status(status), .irq(irq), .err(err)
   );

   logic [31:0] mem_w [0:63];
   logic        stall_en = 1'b0;
   logic [1:0]  rdy_cnt = '0;

   always @(posedge clk) begin
      rsp_valid  <= rd_valid && rd_ready;
      rsp_data   <= mem_w[rd_addr[7:2]];
      rdy_cnt    <= rdy_cnt + 1'b1;
      xfer_ready <= !stall_en || rdy_cnt[1];
   end

   int          total = 0, bad = 0, cyc = 0;
   int          nbeat, nirq, nerr, nrd;
   logic [31:0] first_rd;
   logic [31:0] log_mem [0:4095];
   logic [31:0] log_dev [0:4095];
   logic        log_dir [0:4095];
   logic [1:0]  log_sz  [0:4095];

   always @(negedge clk) begin
      if (rst_n) begin
         if (xfer_valid && xfer_ready) begin
            if (nbeat < 4096) begin
               log_mem[nbeat] = xfer_mem_addr;
               log_dev[nbeat] = xfer_dev_addr;
               log_dir[nbeat] = xfer_to_dev;
               log_sz[nbeat]  = xfer_size;
            end
            nbeat++;
         end
         if (irq) nirq++;
         if (err) nerr++;
         if (rd_valid && rd_ready) begin
            if (nrd == 0) first_rd = rd_addr;
            nrd++;
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic clr();
      nbeat = 0; nirq = 0; nerr = 0; nrd = 0; first_rd = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic kick(input logic [1:0] m, input logic d);
      @(posedge clk); #1;
      mode = m; dir = d; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int g = 0;
      while (status != 2'd0 && g < 20000) begin
         @(negedge clk); #1;
         g++;
      end
      @(negedge clk); #1;
   endtask

   // vector: {dir, width code, count, link flags, expect error}
   localparam logic [16:0] VEC [0:8] = '{
      {1'b1, 2'd3, 11'd5,     2'd1, 1'b0},
      {1'b0, 2'd2, 11'd4,     2'd0, 1'b0},
      {1'b1, 2'd0, 11'd3,     2'd3, 1'b0},
      {1'b0, 2'd1, 11'd2,     2'd1, 1'b1},
      {1'b1, 2'd3, 11'h400,   2'd1, 1'b1},
      {1'b0, 2'd2, 11'h3FF,   2'd0, 1'b0},
      {1'b1, 2'd0, 11'h7FF,   2'd1, 1'b0},
      {1'b0, 2'd3, 11'd0,     2'd1, 1'b0},
      {1'b1, 2'd2, 11'h400,   2'd0, 1'b1}
   };

   initial begin
      for (int i = 0; i < 64; i++) mem_w[i] = '0;
      mem_w[16] = 32'h1100; mem_w[17] = 32'h2000; mem_w[18] = (32'd3 << 12) | 32'd4; mem_w[19] = 32'h62;
      mem_w[24] = 32'h1200; mem_w[25] = 32'h3000; mem_w[26] = (32'd2 << 12) | 32'd3; mem_w[27] = 32'h83;
      mem_w[32] = 32'h1300; mem_w[33] = 32'h4000; mem_w[34] = 32'd2;                 mem_w[35] = 32'h1;
      clr();

      repeat (3) @(posedge clk);
      #1;
      chk(status == 2'd0 && !xfer_valid && !rd_valid && !irq && !err, "R1 reset outputs",
          {status, xfer_valid, rd_valid, irq, err}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(status == 2'd0 && !xfer_valid && !rd_valid, "R1 after release", {30'd0, status}, 32'h0);

      // table walk: single-shot transfers
      for (int v = 0; v < 9; v++) begin
         logic        vd;
         logic [1:0]  wc, fl;
         logic [10:0] cn;
         logic        ve;
         int          expn, stp;
         logic [1:0]  szc;
         logic [31:0] mb, db;
         bit          ok_a, ok_s, ok_d;
         {vd, wc, cn, fl, ve} = VEC[v];
         stp  = (wc == 2'd3) ? 1 : (wc == 2'd2) ? 2 : 4;
         szc  = (wc == 2'd3) ? 2'd0 : (wc == 2'd2) ? 2'd1 : 2'd2;
         expn = ve ? 0 : int'(cn);
         mb   = 32'h10000 + 32'(v) * 32'h100;
         db   = 32'hA000 + 32'(v);
         wr(4'h0, db);
         wr(4'h4, mb);
         wr(4'h8, (32'(wc) << 12) | 32'(cn));
         wr(4'hC, 32'(fl));
         clr();
         kick(2'd2, vd);
         wait_idle();
         ok_a = 1; ok_s = 1; ok_d = 1;
         for (int i = 0; i < nbeat && i < 4096; i++) begin
            if (log_mem[i] != mb + 32'(i * stp) || log_dev[i] != db) ok_a = 0;
            if (log_sz[i] != szc) ok_s = 0;
            if (log_dir[i] != vd) ok_d = 0;
         end
         chk(nbeat == expn, ve ? "R5 no beats on bad size" : "R3 beat count", nbeat, expn);
         chk(ok_a, "R3 addresses per beat (R10 offsets)", v, 1);
         chk(ok_s, "R4 width code", v, szc);
         chk(ok_d, "R11 direction", v, vd);
         chk(nerr == int'(ve), "R5 error pulse", nerr, ve);
         chk(nirq == int'(!ve && fl[0]), "R6 irq count", nirq, (!ve && fl[0]));
         chk(nrd == 0, "R6 single-shot ignores follow flag", nrd, 0);
      end

      // R2: start with mode off or mode 3 ignored
      clr();
      kick(2'd0, 1'b0);
      repeat (4) @(negedge clk);
      #1;
      chk(status == 2'd0 && nbeat == 0, "R2 start with mode 0", {30'd0, status}, 0);
      kick(2'd3, 1'b0);
      repeat (4) @(negedge clk);
      #1;
      chk(status == 2'd0 && nbeat == 0 && nrd == 0, "R2 start with mode 3", nbeat, 0);

      // R2/R10: writes and start while busy are ignored
      wr(4'h0, 32'h7000);
      wr(4'h4, 32'h5000);
      wr(4'h8, (32'd2 << 12) | 32'd8);
      wr(4'hC, 32'h0);
      stall_en = 1'b1;
      clr();
      kick(2'd2, 1'b0);
      repeat (3) @(posedge clk);
      #1;
      cfg_we = 1'b1; cfg_addr = 4'h4; cfg_wdata = 32'h9990;
      @(posedge clk); #1;
      cfg_we = 1'b0; mode = 2'd1; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0; mode = 2'd2;
      wait_idle();
      stall_en = 1'b0;
      begin
         bit ok = 1;
         for (int i = 0; i < 8; i++) if (log_mem[i] != 32'h5000 + 32'(2 * i)) ok = 0;
         chk(nbeat == 8, "R2 busy start adds no beats", nbeat, 8);
         chk(ok, "R10 write while busy ignored", log_mem[1], 32'h5002);
         chk(nrd == 0, "R2 busy start fetches nothing", nrd, 0);
      end

      // R9: abort mid-transfer
      wr(4'h0, 32'h7100);
      wr(4'h4, 32'h6000);
      wr(4'h8, (32'd3 << 12) | 32'd100);
      wr(4'hC, 32'h1);
      clr();
      kick(2'd2, 1'b1);
      while (nbeat < 10) begin
         @(negedge clk); #1;
      end
      @(posedge clk); #1;
      mode = 2'd0;
      wait_idle();
      chk(nbeat == 11, "R9 abort after current beat", nbeat, 11);
      chk(nirq == 0 && status == 2'd0, "R9 no irq on abort", nirq, 0);

      // R7/R6/R8: chained walk of three descriptors
      wr(4'hC, 32'h43);
      clr();
      kick(2'd1, 1'b0);
      chk(status == 2'd1, "R8 fetch status", status, 1);
      wait_idle();
      chk(first_rd == 32'h40, "R7 link flags masked", first_rd, 32'h40);
      chk(nrd == 12, "R7 three descriptors fetched", nrd, 12);
      chk(nbeat == 9, "R6 chain beat total", nbeat, 9);
      chk(nirq == 2, "R6 chain irq count", nirq, 2);
      chk(log_mem[0] == 32'h2000 && log_mem[3] == 32'h2003 && log_mem[4] == 32'h3000 &&
          log_mem[6] == 32'h3004 && log_mem[7] == 32'h4000 && log_mem[8] == 32'h4004,
          "R7 memory word mapping", log_mem[6], 32'h3004);
      chk(log_dev[0] == 32'h1100 && log_dev[4] == 32'h1200 && log_dev[8] == 32'h1300,
          "R7 peripheral word mapping", log_dev[8], 32'h1300);
      chk(log_sz[0] == 2'd0 && log_sz[4] == 2'd1 && log_sz[7] == 2'd2, "R4 per-descriptor width",
          {30'd0, log_sz[4]}, 1);

      // R5 inside a chain: second descriptor rejected
      mem_w[26] = (32'd1 << 12) | 32'd3;
      wr(4'hC, 32'h40);
      clr();
      kick(2'd1, 1'b0);
      wait_idle();
      chk(nbeat == 4, "R5 chain stops at bad descriptor", nbeat, 4);
      chk(nerr == 1 && nirq == 0, "R5 chain error pulse", nerr, 1);
      chk(status == 2'd0, "R5 idle after error", status, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule